// File: doc/BRIEF.md
# Fingerprint Template Store Controller

This block holds a single enrolled fingerprint template and mediates every access to it. The template has up to thirty minutiae. A self bank keeps one 5-bit orientation per minutia. A neighbour bank keeps six 19-bit records per minutia, one for each of its nearest neighbours. Both banks are flip-flop arrays. A record is addressed by a minutia index and a neighbour index, and the neighbour bank word is located at minutia × 6 + neighbour.

Three parties use the store. An enrolment load port fills the banks. It is honoured only while enrolment is enabled and no match is running. The matching engine reads one minutia together with one of its neighbour records per request. A cryptographic engine may read the same records, but only while the security flag from a successful match is high. When both readers ask in the same cycle, the matching engine wins. Every accepted read answers exactly one cycle later.

A control state machine tracks which response is pending. It has four states:
- IDLE: no response pending.
- MRESP: a matching read is answering.
- CRESP: a permitted cryptographic read is answering.
- CDENY: a cryptographic read was refused because the flag was low.

From any state, the next state is chosen by the request seen at the current edge:
- a matching request leads to MRESP;
- otherwise a cryptographic request leads to CRESP when the flag is high, or to CDENY when it is low;
- otherwise the machine goes to IDLE.

Top module: `tsc_template_store`

## Requirements
- R1: After reset, both banks hold zero and m_rvalid, c_rvalid, c_denied and rd_err are 0.
- R2: A load with ld_sel=0, accepted at a clock edge, stores ld_data[4:0] as the orientation of minutia ld_j.
- R3: A load with ld_sel=1, accepted at a clock edge, stores ld_data at neighbour word ld_j*6+ld_kk. The record layout is distance in bits [18:11], angle to the neighbour in [10:5] and neighbour orientation in [4:0], and it is returned unchanged on rd_nbr.
- R4: A load is ignored when enrol_en is 0 or when match_busy is 1.
- R5: A load whose minutia index exceeds 29, or a neighbour load whose neighbour index exceeds 5, changes no stored word.
- R6: A matching request (m_req=1) at an edge gives m_rvalid=1 in the next cycle. In that cycle rd_self and rd_nbr carry the stored orientation and neighbour record for (m_j, m_kk), and rd_err is 0.
- R7: A read with a minutia index above 29 or a neighbour index above 5 answers with rd_err=1 and zero on rd_self and rd_nbr.
- R8: When m_req and c_req are both 1, c_gnt is 0, the matching read is served and no c_rvalid follows.
- R9: A cryptographic request granted while sec_flag is 1 gives c_rvalid=1 and c_denied=0 in the next cycle, carrying the addressed record as in R6.
- R10: A cryptographic request granted while sec_flag is 0 gives c_rvalid=1, c_denied=1, rd_err=0 and all-zero data in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enrol_en | input | 1 | Enrolment window open |
| match_busy | input | 1 | Matching session in progress, blocks loads |
| ld_we | input | 1 | Load strobe |
| ld_sel | input | 1 | 0 selects the self bank, 1 the neighbour bank |
| ld_j | input | 6 | Load minutia index |
| ld_kk | input | 3 | Load neighbour index |
| ld_data | input | 19 | Load data (orientation in bits [4:0] for the self bank) |
| m_req | input | 1 | Matching engine read request |
| m_j | input | 6 | Matching minutia index |
| m_kk | input | 3 | Matching neighbour index |
| c_req | input | 1 | Cryptographic engine read request |
| c_j | input | 6 | Cryptographic minutia index |
| c_kk | input | 3 | Cryptographic neighbour index |
| sec_flag | input | 1 | Match-success flag that gates cryptographic reads |
| c_gnt | output | 1 | Cryptographic request accepted this cycle |
| m_rvalid | output | 1 | Matching response valid |
| c_rvalid | output | 1 | Cryptographic response valid |
| c_denied | output | 1 | Cryptographic response refused |
| rd_err | output | 1 | Response index out of range |
| rd_self | output | 5 | Response minutia orientation |
| rd_nbr | output | 19 | Response neighbour record |

## Verification
The bench builds the block with its default parameters: thirty minutiae, six neighbours, a 6-bit minutia index and a 3-bit neighbour index. With these widths, the indices 30 to 63 and the neighbour indices 6 and 7 can be driven. These out-of-range values alias onto real neighbour words if validation is missing, so the error path and the untouched-storage checks are reachable. The random phase mixes loads under every enrolment and busy combination with reads from both engines against a bench model of the banks.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    localparam int MINUTIAE_DEF = 30;
    localparam int NBRS_DEF     = 6;
    localparam int J_W_DEF      = 6;
    localparam int K_W_DEF      = 3;
    localparam int ANG_W_DEF    = 5;
    localparam int DIST_W_DEF   = 8;
    localparam int PHI_W_DEF    = 6;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_MRESP = 2'd1,
        S_CRESP = 2'd2,
        S_CDENY = 2'd3
    } arb_state_t;
endpackage

// File: rtl/tsc_index_check.sv
module tsc_index_check #(
    parameter int MINUTIAE = 30,
    parameter int NBRS     = 6,
    parameter int J_W      = 6,
    parameter int K_W      = 3,
    parameter int ADDR_W   = 8
) (
    input  logic [J_W-1:0]    j,
    input  logic [K_W-1:0]    kk,
    output logic              j_ok,
    output logic              pair_ok,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        j_ok    = int'(j) < MINUTIAE;
        pair_ok = j_ok && (int'(kk) < NBRS);
        addr    = '0;
        if (pair_ok) begin
            addr = ADDR_W'(int'(j) * NBRS + int'(kk));
        end
    end
endmodule

// File: rtl/tsc_banks.sv
module tsc_banks #(
    parameter int MINUTIAE = 30,
    parameter int NBRS     = 6,
    parameter int J_W      = 6,
    parameter int ANG_W    = 5,
    parameter int NBR_W    = 19,
    parameter int ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              self_we,
    input  logic              nbr_we,
    input  logic [J_W-1:0]    w_j,
    input  logic [ADDR_W-1:0] w_addr,
    input  logic [NBR_W-1:0]  w_data,
    input  logic [J_W-1:0]    r_j,
    input  logic [ADDR_W-1:0] r_addr,
    output logic [ANG_W-1:0]  r_self,
    output logic [NBR_W-1:0]  r_nbr
);
    localparam int NBR_WORDS = MINUTIAE * NBRS;

    logic [ANG_W-1:0] self_mem [MINUTIAE];
    logic [NBR_W-1:0] nbr_mem  [NBR_WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < MINUTIAE; w++) self_mem[w] <= '0;
        end else if (self_we) begin
            for (int w = 0; w < MINUTIAE; w++) begin
                if (int'(w_j) == w) self_mem[w] <= w_data[ANG_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < NBR_WORDS; w++) nbr_mem[w] <= '0;
        end else if (nbr_we) begin
            for (int w = 0; w < NBR_WORDS; w++) begin
                if (int'(w_addr) == w) nbr_mem[w] <= w_data;
            end
        end
    end

    always_comb begin
        r_self = '0;
        for (int w = 0; w < MINUTIAE; w++) begin
            if (int'(r_j) == w) r_self = self_mem[w];
        end
    end

    always_comb begin
        r_nbr = '0;
        for (int w = 0; w < NBR_WORDS; w++) begin
            if (int'(r_addr) == w) r_nbr = nbr_mem[w];
        end
    end
endmodule

// File: rtl/tsc_arbiter.sv
module tsc_arbiter
    import tsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic m_req,
    input  logic c_req,
    input  logic sec_flag,
    output logic use_crypto,
    output logic fetch,
    output logic c_gnt,
    output logic m_rvalid,
    output logic c_rvalid,
    output logic c_denied
);
    arb_state_t state_q, state_d;

    // Next-state choice: matching first, then cryptographic (permitted or refused).
    always_comb begin
        if (m_req) begin
            state_d = S_MRESP;
        end else if (c_req) begin
            state_d = sec_flag ? S_CRESP : S_CDENY;
        end else begin
            state_d = S_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Request-side strobes for the current cycle.
    always_comb begin
        c_gnt      = c_req && !m_req;
        use_crypto = c_gnt;
        fetch      = m_req || (c_gnt && sec_flag);
    end

    // Response-side flags from the pending state.
    always_comb begin
        m_rvalid = 1'b0;
        c_rvalid = 1'b0;
        c_denied = 1'b0;
        unique case (state_q)
            S_IDLE:  ;
            S_MRESP: m_rvalid = 1'b1;
            S_CRESP: c_rvalid = 1'b1;
            S_CDENY: begin
                c_rvalid = 1'b1;
                c_denied = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/tsc_template_store.sv
module tsc_template_store #(
    parameter int MINUTIAE = tsc_pkg::MINUTIAE_DEF,
    parameter int NBRS     = tsc_pkg::NBRS_DEF,
    parameter int J_W      = tsc_pkg::J_W_DEF,
    parameter int K_W      = tsc_pkg::K_W_DEF,
    parameter int ANG_W    = tsc_pkg::ANG_W_DEF,
    parameter int DIST_W   = tsc_pkg::DIST_W_DEF,
    parameter int PHI_W    = tsc_pkg::PHI_W_DEF,
    localparam int NBR_W   = DIST_W + PHI_W + ANG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enrol_en,
    input  logic              match_busy,
    input  logic              ld_we,
    input  logic              ld_sel,
    input  logic [J_W-1:0]    ld_j,
    input  logic [K_W-1:0]    ld_kk,
    input  logic [NBR_W-1:0]  ld_data,
    input  logic              m_req,
    input  logic [J_W-1:0]    m_j,
    input  logic [K_W-1:0]    m_kk,
    input  logic              c_req,
    input  logic [J_W-1:0]    c_j,
    input  logic [K_W-1:0]    c_kk,
    input  logic              sec_flag,
    output logic              c_gnt,
    output logic              m_rvalid,
    output logic              c_rvalid,
    output logic              c_denied,
    output logic              rd_err,
    output logic [ANG_W-1:0]  rd_self,
    output logic [NBR_W-1:0]  rd_nbr
);
    localparam int NBR_WORDS = MINUTIAE * NBRS;
    localparam int ADDR_W    = $clog2(NBR_WORDS);

    // Load side
    logic              ld_j_ok, ld_pair_ok, ld_window;
    logic [ADDR_W-1:0] ld_addr;
    logic              self_we, nbr_we;

    tsc_index_check #(
        .MINUTIAE(MINUTIAE), .NBRS(NBRS), .J_W(J_W), .K_W(K_W), .ADDR_W(ADDR_W)
    ) u_ld_idx (
        .j(ld_j), .kk(ld_kk), .j_ok(ld_j_ok), .pair_ok(ld_pair_ok), .addr(ld_addr)
    );

    always_comb begin
        ld_window = ld_we && enrol_en && !match_busy;
        self_we   = ld_window && !ld_sel && ld_j_ok;
        nbr_we    = ld_window &&  ld_sel && ld_pair_ok;
    end

    // Read side
    logic              use_crypto, fetch;
    logic [J_W-1:0]    rd_j;
    logic [K_W-1:0]    rd_kk;
    logic              rd_j_ok, rd_pair_ok;
    logic [ADDR_W-1:0] rd_addr;
    logic [ANG_W-1:0]  bank_self;
    logic [NBR_W-1:0]  bank_nbr;

    tsc_arbiter u_arb (
        .clk(clk), .rst_n(rst_n), .m_req(m_req), .c_req(c_req), .sec_flag(sec_flag),
        .use_crypto(use_crypto), .fetch(fetch), .c_gnt(c_gnt),
        .m_rvalid(m_rvalid), .c_rvalid(c_rvalid), .c_denied(c_denied)
    );

    always_comb begin
        rd_j  = use_crypto ? c_j  : m_j;
        rd_kk = use_crypto ? c_kk : m_kk;
    end

    tsc_index_check #(
        .MINUTIAE(MINUTIAE), .NBRS(NBRS), .J_W(J_W), .K_W(K_W), .ADDR_W(ADDR_W)
    ) u_rd_idx (
        .j(rd_j), .kk(rd_kk), .j_ok(rd_j_ok), .pair_ok(rd_pair_ok), .addr(rd_addr)
    );

    tsc_banks #(
        .MINUTIAE(MINUTIAE), .NBRS(NBRS), .J_W(J_W), .ANG_W(ANG_W),
        .NBR_W(NBR_W), .ADDR_W(ADDR_W)
    ) u_banks (
        .clk(clk), .rst_n(rst_n),
        .self_we(self_we), .nbr_we(nbr_we),
        .w_j(ld_j), .w_addr(ld_addr), .w_data(ld_data),
        .r_j(rd_j), .r_addr(rd_addr),
        .r_self(bank_self), .r_nbr(bank_nbr)
    );

    // Response registers: data only when a permitted fetch hits a valid index.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_self <= '0;
            rd_nbr  <= '0;
            rd_err  <= 1'b0;
        end else begin
            rd_err <= fetch && !rd_pair_ok;
            if (fetch && rd_pair_ok) begin
                rd_self <= bank_self;
                rd_nbr  <= bank_nbr;
            end else begin
                rd_self <= '0;
                rd_nbr  <= '0;
            end
        end
    end
endmodule

// File: rtl/tsc_template_store_chk.sv
module tsc_template_store_chk #(
    parameter int ANG_W = 5,
    parameter int NBR_W = 19
) (
    input logic             clk,
    input logic             rst_n,
    input logic             m_req,
    input logic             c_req,
    input logic             c_gnt,
    input logic             sec_flag,
    input logic             m_rvalid,
    input logic             c_rvalid,
    input logic             c_denied,
    input logic             rd_err,
    input logic [ANG_W-1:0] rd_self,
    input logic [NBR_W-1:0] rd_nbr
);
    a_r6_match_answers: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |=> m_rvalid);

    a_r8_match_first: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && c_req) |-> !c_gnt);

    a_r8_no_crypto_resp: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |=> !c_rvalid);

    a_r9_granted_read: assert property (@(posedge clk) disable iff (!rst_n)
        (c_gnt && sec_flag) |=> (c_rvalid && !c_denied));

    a_r10_refused_read: assert property (@(posedge clk) disable iff (!rst_n)
        (c_gnt && !sec_flag) |=> (c_rvalid && c_denied && !rd_err && rd_self == '0 && rd_nbr == '0));

    a_r7_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rd_self == '0 && rd_nbr == '0));

    a_r6_single_resp: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({m_rvalid, c_rvalid}));
endmodule

bind tsc_template_store tsc_template_store_chk #(.ANG_W(ANG_W), .NBR_W(NBR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .c_req(c_req), .c_gnt(c_gnt),
    .sec_flag(sec_flag), .m_rvalid(m_rvalid), .c_rvalid(c_rvalid),
    .c_denied(c_denied), .rd_err(rd_err), .rd_self(rd_self), .rd_nbr(rd_nbr)
);

// File: tb/tsc_template_store_test.sv
`timescale 1ns/1ps
module tsc_template_store_test;
    localparam int MIN_N = 30;
    localparam int NB_N  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enrol_en = 1'b0, match_busy = 1'b0;
    logic        ld_we = 1'b0, ld_sel = 1'b0;
    logic [5:0]  ld_j = '0;
    logic [2:0]  ld_kk = '0;
    logic [18:0] ld_data = '0;
    logic        m_req = 1'b0, c_req = 1'b0, sec_flag = 1'b0;
    logic [5:0]  m_j = '0, c_j = '0;
    logic [2:0]  m_kk = '0, c_kk = '0;
    logic        c_gnt, m_rvalid, c_rvalid, c_denied, rd_err;
    logic [4:0]  rd_self;
    logic [18:0] rd_nbr;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [4:0]  ref_self [MIN_N];
    logic [18:0] ref_nbr  [MIN_N*NB_N];

    always #4 clk = ~clk;

    tsc_template_store uut (
        .clk(clk), .rst_n(rst_n), .enrol_en(enrol_en), .match_busy(match_busy),
        .ld_we(ld_we), .ld_sel(ld_sel), .ld_j(ld_j), .ld_kk(ld_kk), .ld_data(ld_data),
        .m_req(m_req), .m_j(m_j), .m_kk(m_kk),
        .c_req(c_req), .c_j(c_j), .c_kk(c_kk), .sec_flag(sec_flag),
        .c_gnt(c_gnt), .m_rvalid(m_rvalid), .c_rvalid(c_rvalid), .c_denied(c_denied),
        .rd_err(rd_err), .rd_self(rd_self), .rd_nbr(rd_nbr)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit pair_ok(input logic [5:0] j, input logic [2:0] kk);
        return (int'(j) < MIN_N) && (int'(kk) < NB_N);
    endfunction

    function automatic bit load_taken(input bit en, input bit busy, input bit sel,
                                      input logic [5:0] j, input logic [2:0] kk);
        if (!en || busy) return 0;
        if (!sel) return int'(j) < MIN_N;
        return pair_ok(j, kk);
    endfunction

    task automatic do_load(input bit en, input bit busy, input bit sel,
                           input logic [5:0] j, input logic [2:0] kk, input logic [18:0] d);
        @(negedge clk);
        enrol_en = en; match_busy = busy; ld_we = 1'b1; ld_sel = sel;
        ld_j = j; ld_kk = kk; ld_data = d;
        @(posedge clk);
        if (load_taken(en, busy, sel, j, kk)) begin
            if (!sel) ref_self[int'(j)] = d[4:0];
            else      ref_nbr[int'(j)*NB_N + int'(kk)] = d;
        end
        @(negedge clk);
        ld_we = 1'b0; enrol_en = 1'b0; match_busy = 1'b0;
    endtask

    // Read by one engine and compare the response one cycle later.
    task automatic do_read(input string req, input bit crypto, input bit flag,
                           input logic [5:0] j, input logic [2:0] kk);
        bit ok, deny;
        logic [4:0]  e_self;
        logic [18:0] e_nbr;
        @(negedge clk);
        sec_flag = flag;
        if (crypto) begin c_req = 1'b1; c_j = j; c_kk = kk; end
        else        begin m_req = 1'b1; m_j = j; m_kk = kk; end
        #1;
        chk(req, "c_gnt", 32'(c_gnt), 32'(crypto));
        ok   = pair_ok(j, kk);
        deny = crypto && !flag;
        e_self = (ok && !deny) ? ref_self[int'(j)] : 5'd0;
        e_nbr  = (ok && !deny) ? ref_nbr[int'(j)*NB_N + int'(kk)] : 19'd0;
        @(negedge clk);
        m_req = 1'b0; c_req = 1'b0;
        chk(req, "m_rvalid", 32'(m_rvalid), 32'(!crypto));
        chk(req, "c_rvalid", 32'(c_rvalid), 32'(crypto));
        chk(req, "c_denied", 32'(c_denied), 32'(deny));
        chk(req, "rd_err",   32'(rd_err),   32'(!ok && !deny));
        chk(req, "rd_self",  32'(rd_self),  32'(e_self));
        chk(req, "rd_nbr",   32'(rd_nbr),   32'(e_nbr));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd51423);
        for (int i = 0; i < MIN_N; i++) ref_self[i] = '0;
        for (int i = 0; i < MIN_N*NB_N; i++) ref_nbr[i] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of outputs and banks
        chk("R1", "m_rvalid", 32'(m_rvalid), 0);
        chk("R1", "c_rvalid", 32'(c_rvalid), 0);
        chk("R1", "rd_err",   32'(rd_err),   0);
        do_read("R1", 0, 0, 6'd0, 3'd0);
        do_read("R1", 0, 0, 6'd29, 3'd5);

        // R2 / R3: directed loads at the corners, field layout dist|phi|nang
        do_load(1, 0, 0, 6'd29, 3'd0, 19'h0001D);
        do_load(1, 0, 0, 6'd0,  3'd0, 19'h7FFE3);
        do_load(1, 0, 1, 6'd29, 3'd5, {8'hA5, 6'h2C, 5'h13});
        do_load(1, 0, 1, 6'd0,  3'd0, {8'h3C, 6'h15, 5'h0A});
        do_load(1, 0, 1, 6'd1,  3'd0, {8'h77, 6'h01, 5'h1F});
        do_read("R2", 0, 0, 6'd29, 3'd5);
        do_read("R3", 0, 0, 6'd0,  3'd0);
        do_read("R3", 0, 0, 6'd1,  3'd0);
        chk("R3", "distance field", 32'(ref_nbr[179][18:11]), 32'h0A5);

        // R4: loads outside the enrolment window or during a match
        do_load(0, 0, 1, 6'd1, 3'd0, 19'h12345);
        do_load(1, 1, 1, 6'd1, 3'd0, 19'h54321);
        do_load(0, 1, 0, 6'd0, 3'd0, 19'h00007);
        do_read("R4", 0, 0, 6'd1, 3'd0);
        do_read("R4", 0, 0, 6'd0, 3'd0);

        // R5: out-of-range loads must not alias onto neighbouring words
        do_load(1, 0, 1, 6'd0,  3'd6, 19'h0BEEF);
        do_load(1, 0, 1, 6'd29, 3'd7, 19'h0CAFE);
        do_load(1, 0, 0, 6'd30, 3'd0, 19'h00015);
        do_load(1, 0, 1, 6'd30, 3'd0, 19'h0F00D);
        do_read("R5", 0, 0, 6'd1, 3'd0);
        do_read("R5", 0, 0, 6'd29, 3'd5);
        do_read("R5", 1, 1, 6'd0, 3'd0);

        // R7: invalid read indices
        do_read("R7", 0, 0, 6'd30, 3'd0);
        do_read("R7", 0, 0, 6'd0,  3'd6);
        do_read("R7", 1, 1, 6'd63, 3'd7);

        // R8: simultaneous requests
        @(negedge clk);
        m_req = 1'b1; m_j = 6'd29; m_kk = 3'd5;
        c_req = 1'b1; c_j = 6'd0;  c_kk = 3'd0; sec_flag = 1'b1;
        #1;
        chk("R8", "c_gnt", 32'(c_gnt), 0);
        @(negedge clk);
        m_req = 1'b0; c_req = 1'b0;
        chk("R8", "m_rvalid", 32'(m_rvalid), 1);
        chk("R8", "c_rvalid", 32'(c_rvalid), 0);
        chk("R8", "rd_nbr",   32'(rd_nbr), 32'(ref_nbr[179]));

        // R9 / R10: gated cryptographic access
        do_read("R9",  1, 1, 6'd29, 3'd5);
        do_read("R10", 1, 0, 6'd29, 3'd5);
        do_read("R10", 1, 0, 6'd40, 3'd7);

        // Random mix
        for (int it = 0; it < 800; it++) begin
            int unsigned op;
            logic [5:0]  rj;
            logic [2:0]  rk;
            op = $urandom_range(0, 9);
            rj = ($urandom_range(0, 7) == 0) ? 6'($urandom_range(30, 63)) : 6'($urandom_range(0, 29));
            rk = ($urandom_range(0, 7) == 0) ? 3'($urandom_range(6, 7))   : 3'($urandom_range(0, 5));
            if (op < 4) begin
                do_load($urandom_range(0, 3) != 0, $urandom_range(0, 3) == 0,
                        1'($urandom_range(0, 1)), rj, rk, 19'($urandom));
            end else if (op < 7) begin
                do_read("R6", 0, 1'($urandom_range(0, 1)), rj, rk);
            end else begin
                do_read("R9", 1, $urandom_range(0, 3) != 0, rj, rk);
            end
        end

        finish_run();
    end
endmodule